// File: doc/BRIEF.md
# Multiplexed-Address Burst Write Slave

This block is a synchronous target on a host bus where address and data share one set of wires. A transfer opens with the host driving select low, putting the start address on the shared bus and raising an address-latch pulse for one clock. On the very next clock the host pulses the data strobe low for one cycle. This arms a sequential burst. From then on the target takes one data word from the bus on every rising edge. The host keeps last high until the final word. The target ends the burst on the edge where it sees last low.

Each captured word comes out on a simple memory-write port. That port carries a write pulse, a word address, the 32-bit data and a two-bit half-word mask taken from the host's word enables. The word address starts at the latched value and increases by one per captured word. A stop output tells the host to hold its current word while a downstream command queue reports full. The ready output is low while the burst is still expecting more words. Read cycles are not served: a strobe with the read/write select at read is dropped.

Top module: `mux_burst_wr_slave`

## Requirements
- R1: With select low in the idle state, a high level on the address-latch input at a rising edge captures bus bits [AW-1:0] as the start word address. The first write of the burst that follows uses that address.
- R2: The burst is armed only when the data strobe is low, select is low and read/write select is 0 (write) on the edge that directly follows the latch edge. Any other input on that edge returns the block to idle, and no write results.
- R3: A data strobe with no address latch on the previous edge produces no write and leaves ready high. This includes a latch pulse given while select was high.
- R4: In a burst, each rising edge with select low and stop high captures the bus word. It produces exactly one one-cycle mem_we pulse with that data in the following cycle. Successive writes use consecutive word addresses, modulo 2^AW.
- R5: Ready (active low) is 0 in the cycle after a captured word whose last input was 1. It is 1 in the cycle after the word captured with last at 0.
- R6: The word captured with last at 0 is the final one. Later edges produce no write until a new latch and strobe sequence.
- R7: Select going high during a burst aborts it. That edge produces no write, and ready is 1 in the following cycle.
- R8: mem_wmask equals the word-enable input sampled with the word. Bit 0 covers data bits [15:0] and bit 1 covers bits [31:16]. A 0 bit means that half is not written.
- R9: Stop (active low) is the registered inverse of the queue-full input, one cycle later. It is 1 out of reset.
- R10: No word is captured on an edge where stop is 0. The burst resumes at the next address once stop returns to 1.
- R11: After reset, ready and stop are 1 and mem_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low target select |
| addr_lat | input | 1 | Address-latch pulse, active high |
| dstb_n | input | 1 | Active-low one-cycle burst start strobe |
| rd_wr_n | input | 1 | 1 = read (ignored), 0 = write |
| last_n | input | 1 | Active-low final-word marker |
| hw_en | input | LANES | Half-word write enables, bit 0 = low half |
| bus_data | input | DW | Shared address/data bus |
| q_full | input | 1 | Downstream command queue full |
| rdy_n | output | 1 | Active-low ready |
| stop_n | output | 1 | Active-low stop (back-pressure) |
| mem_we | output | 1 | Memory write pulse |
| mem_addr | output | AW | Word address of the write |
| mem_wdata | output | DW | Write data |
| mem_wmask | output | LANES | Half-word write mask |

## Verification
The bench builds the block with AW = 4, DW = 32 and LANES = 2. The narrow address lets a four-word burst starting at word 14 cross from 15 back to 0, so address wrap is checked with a short run. The 32-bit data and two lanes are the real widths, so every mask pattern from 00 to 11 is driven against known data. Queue-full stalls, aborts and malformed starts are each placed on a specific edge so that the one-cycle latencies of stop and ready are observed exactly.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BURST = 2'd2
  } mbw_state_e;
endpackage

// File: rtl/mbw_rst_sync.sv
module mbw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbw_ctrl.sv
module mbw_ctrl
  import mbw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic addr_lat,
  input  logic dstb_n,
  input  logic rd_wr_n,
  input  logic last_n,
  input  logic q_full,
  output logic load,
  output logic cap,
  output logic rdy_n,
  output logic stop_n
);
  mbw_state_e state_q, state_d;
  logic       rdy_q, rdy_d, rdy_en;
  logic       stop_q;
  logic       go;

  // R1 R2 R3: start sequence decode
  always_comb begin
    load = (state_q == ST_IDLE) && !sel_n && addr_lat;
    go   = (state_q == ST_ARMED) && !sel_n && !dstb_n && !rd_wr_n;
    // R4 R10: capture only when selected and not stalled
    cap  = (state_q == ST_BURST) && !sel_n && stop_q;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_ARMED;
      ST_ARMED: state_d = go ? ST_BURST : ST_IDLE;
      ST_BURST: begin
        if (sel_n)                state_d = ST_IDLE;  // R7
        else if (cap && !last_n)  state_d = ST_IDLE;  // R6
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  // R5 R7: ready updates on capture or abort only
  always_comb begin
    rdy_en = (state_q == ST_BURST) && (sel_n || cap);
    rdy_d  = sel_n ? 1'b1 : ~last_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b1;
      stop_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (rdy_en) rdy_q <= rdy_d;
      stop_q  <= ~q_full;  // R9
    end
  end

  assign rdy_n  = rdy_q;
  assign stop_n = stop_q;
endmodule

// File: rtl/mbw_wport.sv
module mbw_wport #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cap,
  input  logic [DW-1:0]    bus_data,
  input  logic [LANES-1:0] hw_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_wmask
);
  localparam int LW = DW / LANES;

  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  // R1 R4: word pointer loads from the bus and steps per capture
  always_comb begin
    ptr_en = load || cap;
    ptr_d  = load ? bus_data[AW-1:0] : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wmask <= '0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      mem_we <= cap;
      if (cap) begin
        mem_addr  <= ptr_q;
        mem_wmask <= hw_en;  // R8
      end
    end
  end

  // R8: one data register per half-word lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_wdata[g*LW +: LW] <= '0;
      else if (cap) mem_wdata[g*LW +: LW] <= bus_data[g*LW +: LW];
    end
  end
endmodule

// File: rtl/mux_burst_wr_slave.sv
module mux_burst_wr_slave #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             addr_lat,
  input  logic             dstb_n,
  input  logic             rd_wr_n,
  input  logic             last_n,
  input  logic [LANES-1:0] hw_en,
  input  logic [DW-1:0]    bus_data,
  input  logic             q_full,
  output logic             rdy_n,
  output logic             stop_n,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_wmask
);
  logic srst_n;
  logic load, cap;

  mbw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mbw_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .sel_n(sel_n), .addr_lat(addr_lat),
    .dstb_n(dstb_n), .rd_wr_n(rd_wr_n), .last_n(last_n), .q_full(q_full),
    .load(load), .cap(cap), .rdy_n(rdy_n), .stop_n(stop_n)
  );

  mbw_wport #(.AW(AW), .DW(DW), .LANES(LANES)) u_wport (
    .clk(clk), .rst_n(srst_n), .load(load), .cap(cap),
    .bus_data(bus_data), .hw_en(hw_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask)
  );
endmodule

// File: rtl/mbw_chk.sv
module mbw_chk #(
  parameter int AW    = 16,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             srst_n,
  input logic             sel_n,
  input logic             last_n,
  input logic [LANES-1:0] hw_en,
  input logic             q_full,
  input logic             rdy_n,
  input logic             stop_n,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [LANES-1:0] mem_wmask
);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 1'b1);

  // R5
  rdy_follows_last_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we |-> rdy_n == !$past(last_n));

  // R7
  write_needs_sel_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we |-> $past(!sel_n));

  // R8
  mask_copy_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we |-> mem_wmask == $past(hw_en));

  // R9
  stop_set_chk: assert property (@(posedge clk) disable iff (!srst_n)
    q_full |=> !stop_n);

  // R9
  stop_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !q_full |=> stop_n);

  // R10
  no_write_on_stop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we |-> $past(stop_n));
endmodule

bind mux_burst_wr_slave mbw_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .srst_n(srst_n), .sel_n(sel_n), .last_n(last_n),
  .hw_en(hw_en), .q_full(q_full), .rdy_n(rdy_n), .stop_n(stop_n),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wmask(mem_wmask)
);

// File: tb/mux_burst_wr_slave_tb.sv
`timescale 1ns/1ps
module mux_burst_wr_slave_tb;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int LANES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, addr_lat = 1'b0, dstb_n = 1'b1, rd_wr_n = 1'b1, last_n = 1'b1;
  logic [LANES-1:0] hw_en = 2'b11;
  logic [DW-1:0] bus_data = '0;
  logic q_full = 1'b0;
  logic rdy_n, stop_n, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [LANES-1:0] mem_wmask;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  mux_burst_wr_slave #(.AW(AW), .DW(DW), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr_lat(addr_lat),
    .dstb_n(dstb_n), .rd_wr_n(rd_wr_n), .last_n(last_n), .hw_en(hw_en),
    .bus_data(bus_data), .q_full(q_full), .rdy_n(rdy_n), .stop_n(stop_n),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask)
  );

  // write log, sampled at the falling edge
  logic [AW-1:0]    lg_addr [0:63];
  logic [DW-1:0]    lg_data [0:63];
  logic [LANES-1:0] lg_mask [0:63];
  int lg_n = 0;

  always @(negedge clk) begin
    if (mem_we && lg_n < 64) begin
      lg_addr[lg_n] = mem_addr;
      lg_data[lg_n] = mem_wdata;
      lg_mask[lg_n] = mem_wmask;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_idle();
    sel_n = 1'b1; addr_lat = 1'b0; dstb_n = 1'b1; rd_wr_n = 1'b1;
    last_n = 1'b1; hw_en = 2'b11; bus_data = '0;
  endtask

  task automatic open_burst(input logic [AW-1:0] a);
    sel_n = 1'b0; addr_lat = 1'b1; bus_data = 32'hA5C3_0000 | 32'(a);
    step();
    addr_lat = 1'b0; dstb_n = 1'b0; rd_wr_n = 1'b0; bus_data = 32'h0;
    step();
    dstb_n = 1'b1;
  endtask

  function automatic logic [DW-1:0] word_of(input int seed, input int i);
    return 32'h1000_0001 * (seed + 1) + 32'h0101_0101 * i;
  endfunction

  // drive n words, check each write and ready on the next cycle
  task automatic run_words(input logic [AW-1:0] a, input int n, input int seed,
                           input bit vary_mask);
    int base;
    base = lg_n;
    for (int i = 0; i < n; i++) begin
      bus_data = word_of(seed, i);
      hw_en = vary_mask ? 2'(i) : 2'b11;
      last_n = (i == n - 1) ? 1'b0 : 1'b1;
      step();
      chk(lg_n == base + i + 1, "R4", "write count", lg_n, base + i + 1);
      chk(lg_addr[base+i] == AW'(a + i), "R4", "write address",
          lg_addr[base+i], AW'(a + i));
      chk(lg_data[base+i] == word_of(seed, i), "R4", "write data",
          lg_data[base+i], word_of(seed, i));
      chk(lg_mask[base+i] == (vary_mask ? 2'(i) : 2'b11), "R8", "mask",
          lg_mask[base+i], vary_mask ? 2'(i) : 2'b11);
      chk(rdy_n == (i == n - 1), "R5", "ready after word", rdy_n, i == n - 1);
    end
    last_n = 1'b1;
  endtask

  task automatic t_reset();
    q_full = 1'b1;
    repeat (3) step();
    chk(rdy_n == 1'b1, "R11", "ready in reset", rdy_n, 1);
    chk(stop_n == 1'b1, "R11", "stop in reset", stop_n, 1);
    chk(mem_we == 1'b0, "R11", "we in reset", mem_we, 0);
    q_full = 1'b0;
    rst_n = 1'b1;
    repeat (4) step();
    chk(rdy_n == 1'b1 && stop_n == 1'b1 && mem_we == 1'b0, "R11",
        "outputs after reset", {rdy_n, stop_n, mem_we}, 3'b110);
  endtask

  task automatic t_basic();
    int base;
    open_burst(4'd3);
    chk(lg_n == 0 && rdy_n == 1'b1, "R1", "no write before data", lg_n, 0);
    run_words(4'd3, 4, 0, 1'b1);
    chk(lg_addr[0] == 4'd3, "R1", "start address", lg_addr[0], 3);
    // R6: keep select low and strobe again with data: nothing written
    base = lg_n;
    dstb_n = 1'b0; bus_data = 32'hDEAD_BEEF;
    step();
    dstb_n = 1'b1;
    step(); step();
    chk(lg_n == base, "R6", "no write after final word", lg_n, base);
    chk(rdy_n == 1'b1, "R6", "ready stays high", rdy_n, 1);
    bus_idle();
    step();
  endtask

  task automatic t_wrap();
    open_burst(4'd14);
    run_words(4'd14, 4, 3, 1'b0);
    bus_idle();
    step();
  endtask

  task automatic t_single();
    int base;
    base = lg_n;
    open_burst(4'd9);
    run_words(4'd9, 1, 5, 1'b0);
    chk(lg_n == base + 1, "R6", "single word burst", lg_n, base + 1);
    bus_idle();
    step();
  endtask

  task automatic t_no_latch();
    int base;
    base = lg_n;
    // strobe with no latch
    sel_n = 1'b0; dstb_n = 1'b0; rd_wr_n = 1'b0; bus_data = 32'h5;
    step();
    dstb_n = 1'b1; bus_data = 32'h1111_2222;
    repeat (3) step();
    chk(lg_n == base, "R3", "strobe without latch", lg_n, base);
    chk(rdy_n == 1'b1, "R3", "ready high", rdy_n, 1);
    // latch with select high, then strobe with select low
    bus_idle();
    step();
    addr_lat = 1'b1; bus_data = 32'h2;
    step();
    addr_lat = 1'b0; sel_n = 1'b0; dstb_n = 1'b0; rd_wr_n = 1'b0;
    step();
    dstb_n = 1'b1; bus_data = 32'h3333_4444;
    repeat (3) step();
    chk(lg_n == base, "R3", "latch while deselected", lg_n, base);
    bus_idle();
    step();
  endtask

  task automatic t_late_strobe();
    int base;
    base = lg_n;
    sel_n = 1'b0; addr_lat = 1'b1; bus_data = 32'h6;
    step();
    addr_lat = 1'b0;
    step();
    dstb_n = 1'b0; rd_wr_n = 1'b0;
    step();
    dstb_n = 1'b1; bus_data = 32'h7777_0000;
    repeat (3) step();
    chk(lg_n == base, "R2", "late strobe ignored", lg_n, base);
    chk(rdy_n == 1'b1, "R2", "ready high", rdy_n, 1);
    bus_idle();
    step();
    // read strobe ignored
    sel_n = 1'b0; addr_lat = 1'b1; bus_data = 32'h8;
    step();
    addr_lat = 1'b0; dstb_n = 1'b0; rd_wr_n = 1'b1;
    step();
    dstb_n = 1'b1; bus_data = 32'h8888_0000;
    repeat (3) step();
    chk(lg_n == base, "R2", "read strobe ignored", lg_n, base);
    bus_idle();
    step();
  endtask

  task automatic t_abort();
    int base;
    base = lg_n;
    open_burst(4'd5);
    bus_data = 32'hAB00_0001; last_n = 1'b1;
    step();
    bus_data = 32'hAB00_0002;
    step();
    chk(lg_n == base + 2 && rdy_n == 1'b0, "R7", "two words before abort",
        lg_n, base + 2);
    sel_n = 1'b1; bus_data = 32'hAB00_0003;
    step();
    chk(lg_n == base + 2, "R7", "no write on abort edge", lg_n, base + 2);
    chk(rdy_n == 1'b1, "R7", "ready after abort", rdy_n, 1);
    sel_n = 1'b0;
    repeat (2) step();
    chk(lg_n == base + 2, "R7", "no write after reselect", lg_n, base + 2);
    bus_idle();
    step();
  endtask

  task automatic t_stall();
    int base;
    base = lg_n;
    open_burst(4'd10);
    bus_data = 32'hC0DE_0000; last_n = 1'b1; q_full = 1'b1;
    step();
    chk(stop_n == 1'b0, "R9", "stop low after full", stop_n, 0);
    chk(lg_n == base + 1, "R10", "first word before stop", lg_n, base + 1);
    bus_data = 32'hC0DE_0001;
    step();
    chk(lg_n == base + 1, "R10", "held while stopped", lg_n, base + 1);
    chk(rdy_n == 1'b0, "R5", "ready held in stall", rdy_n, 0);
    q_full = 1'b0;
    step();
    chk(stop_n == 1'b1, "R9", "stop high after clear", stop_n, 1);
    chk(lg_n == base + 1, "R10", "no capture on stop edge", lg_n, base + 1);
    last_n = 1'b0;
    step();
    chk(lg_n == base + 2, "R10", "resumed capture", lg_n, base + 2);
    chk(lg_addr[base+1] == 4'd11, "R10", "resume address", lg_addr[base+1], 11);
    chk(lg_data[base+1] == 32'hC0DE_0001, "R10", "resume data",
        lg_data[base+1], 32'hC0DE_0001);
    chk(rdy_n == 1'b1, "R5", "ready after final", rdy_n, 1);
    bus_idle();
    step();
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_single();
    t_no_latch();
    t_late_strobe();
    t_abort();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule